// File: doc/BRIEF.md
# Finite-Set Predictive Switching-State Selector

This block picks the gate pattern for a five-pair switched-capacitor multilevel inverter. It does this by exhaustive one-step-ahead prediction. A sample set arrives on a valid/ready handshake. The set holds the measured source voltage, three capacitor voltages, the load current and the grid voltage, the current and capacitor references, and pre-scaled model and weighting coefficients. The block latches the whole set. It then scores every one of the 32 candidate states, one per clock.

For each candidate it predicts the next load current and the next three capacitor voltages using forward-Euler steps in fixed point. It turns the absolute tracking errors into a weighted, normalized cost and keeps the cheapest candidate. After the last candidate it emits a one-cycle `done_o` pulse and applies the winner to ten complementary gate outputs. The outputs then hold until the next evaluation completes.

Back-pressure rules: `smp_ready_o` is high only while the block is idle. A sample set is taken on a clock edge where `smp_valid_i` and `smp_ready_o` are both high. While an evaluation runs, `smp_ready_o` is low and `smp_valid_i` is ignored, so a source that wants its sample used must hold it until ready returns. `done_o` and the gate pins are plain outputs without handshake.

Top module: `mpc_state_picker`

## Requirements
- R1: Candidate state s (0..31) sets swN = bit N-1 of s. `gate_up_o[N-1]` = swN drives the upper switch of pair N, and `gate_dn_o[N-1]` = not swN drives its partner. After reset the gates show state 0: `gate_up_o` = 0 and `gate_dn_o` = 5'b11111.
- R2: `smp_ready_o` is high when idle. A set is accepted on an edge with valid and ready both high. Ready is low from the next cycle until the cycle in which `done_o` is high. Valid seen while ready is low has no effect.
- R3: The predicted current is i_load + ((k_il * V) >>> 14). V = (sw1-sw2)*v_src + (sw2-sw3)*v_c2 + (sw3-sw4)*v_c3 + (sw4-sw5)*v_c4 - v_grid. All values are signed, and the arithmetic is full precision with an arithmetic shift.
- R4: The predicted capacitor voltages are v_c2 + ((k_c2*(sw3-sw2)*i_load) >>> 14), v_c3 + ((k_c3*(sw4-sw3)*i_load) >>> 14) and v_c4 + ((k_c4*(sw5-sw4)*i_load) >>> 14).
- R5: Each error magnitude is |ref - prediction|, clamped to 65535. Each term is (magnitude * norm) >> 14, with the norm unsigned. The cost is (((t_c2+t_c3+t_c4) * lam_v) >> 14) + ((t_i * lam_i) >> 14), with lam_v and lam_i unsigned in Q2.14.
- R6: The cost clamps at 2^20-1 instead of wrapping.
- R7: The state with the smallest cost wins. On equal cost the lower state number wins.
- R8: `done_o` is a one-cycle pulse that is high after the 32nd rising edge following acceptance. The gate outputs change only on that edge.
- R9: Every input is latched at acceptance. Input changes during an evaluation do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | Sample set valid |
| smp_ready_o | output | 1 | Block idle, can accept a set |
| v_src_i | input | 16 | Source voltage, signed |
| v_c2_i | input | 16 | Capacitor 2 voltage, signed |
| v_c3_i | input | 16 | Capacitor 3 voltage, signed |
| v_c4_i | input | 16 | Capacitor 4 voltage, signed |
| i_load_i | input | 16 | Load current, signed |
| v_grid_i | input | 16 | Grid voltage, signed |
| i_ref_i | input | 16 | Current reference, signed |
| c2_ref_i | input | 16 | Capacitor 2 reference, signed |
| c3_ref_i | input | 16 | Capacitor 3 reference, signed |
| c4_ref_i | input | 16 | Capacitor 4 reference, signed |
| k_il_i | input | 16 | Ts/L coefficient, signed Q14 |
| k_c2_i | input | 16 | Ts/C2 coefficient, signed Q14 |
| k_c3_i | input | 16 | Ts/C3 coefficient, signed Q14 |
| k_c4_i | input | 16 | Ts/C4 coefficient, signed Q14 |
| n_i_i | input | 16 | Current error normalizer (reciprocal of limit), unsigned Q14 |
| n_c2_i | input | 16 | Capacitor 2 normalizer, unsigned Q14 |
| n_c3_i | input | 16 | Capacitor 3 normalizer, unsigned Q14 |
| n_c4_i | input | 16 | Capacitor 4 normalizer, unsigned Q14 |
| lam_v_i | input | 16 | Voltage weight, unsigned Q14 |
| lam_i_i | input | 16 | Current weight, unsigned Q14 |
| done_o | output | 1 | One-cycle evaluation-complete pulse |
| gate_up_o | output | 5 | Upper switch of pairs 1..5 |
| gate_dn_o | output | 5 | Partner switch of pairs 1..5 |

## Verification
The bench first targets ties. In one setup, eight candidates share the lowest cost. A design that replaces the winner on equal cost applies the highest of them instead of the lowest.

It drives errors and weights large enough that the raw cost passes 2^20. A design that wraps instead of clamping then lets a huge cost look cheap and picks the wrong state. Separate runs stress the current prediction and the capacitor predictions. In those runs a swapped switch difference or a logical shift on a negative product moves the winner.

Finally, it holds valid high and changes every input during an evaluation. A design that re-samples, accepts early or updates the gates before the done edge shows up at once in the per-cycle comparison of ready, done and the gates.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int NSW = 5;
  localparam int NCAP = 3;

  typedef logic [NSW-1:0] sw_state_t;

  // signed difference of two switch variables: -1, 0 or +1
  function automatic logic signed [1:0] pair_diff(input logic a, input logic b);
    return (a && !b) ? 2'sd1 : ((b && !a) ? -2'sd1 : 2'sd0);
  endfunction
endpackage

// File: rtl/mpc_predict.sv
module mpc_predict
  import mpc_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int PW   = 2*W+8
) (
  input  sw_state_t                sw,
  input  logic signed [W-1:0]      v_src,
  input  logic signed [W-1:0]      v_cap [NCAP],
  input  logic signed [W-1:0]      i_load,
  input  logic signed [W-1:0]      v_grid,
  input  logic signed [W-1:0]      k_il,
  input  logic signed [W-1:0]      k_cap [NCAP],
  output logic signed [PW-1:0]     i_nx,
  output logic signed [PW-1:0]     c_nx [NCAP]
);
  function automatic logic signed [PW-1:0] sx(input logic signed [W-1:0] x);
    return PW'(x);
  endfunction

  logic signed [PW-1:0] vterm [NCAP];
  logic signed [PW-1:0] vsum;
  logic signed [PW-1:0] iprod;

  for (genvar g = 0; g < NCAP; g++) begin : g_cap
    logic signed [PW-1:0] cprod;
    // level contribution of capacitor g into the load loop
    assign vterm[g] = PW'(pair_diff(sw[g+1], sw[g+2])) * sx(v_cap[g]);
    // charge step of capacitor g
    assign cprod    = sx(k_cap[g]) * (PW'(pair_diff(sw[g+2], sw[g+1])) * sx(i_load));
    assign c_nx[g]  = sx(v_cap[g]) + (cprod >>> FRAC);
  end

  always_comb begin
    vsum = PW'(pair_diff(sw[0], sw[1])) * sx(v_src) - sx(v_grid);
    for (int g = 0; g < NCAP; g++) vsum = vsum + vterm[g];
    iprod = sx(k_il) * vsum;
    i_nx  = sx(i_load) + (iprod >>> FRAC);
  end
endmodule

// File: rtl/mpc_cost.sv
module mpc_cost
  import mpc_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int PW   = 2*W+8,
  parameter int CW   = 20
) (
  input  logic signed [PW-1:0] i_nx,
  input  logic signed [PW-1:0] c_nx  [NCAP],
  input  logic signed [W-1:0]  i_ref,
  input  logic signed [W-1:0]  c_ref [NCAP],
  input  logic [W-1:0]         n_i,
  input  logic [W-1:0]         n_cap [NCAP],
  input  logic [W-1:0]         lam_v,
  input  logic [W-1:0]         lam_i,
  output logic [CW-1:0]        cost
);
  localparam logic signed [PW-1:0] MAXM = {{(PW-W){1'b0}}, {W{1'b1}}};
  localparam logic [PW-1:0]        CMAX = {{(PW-CW){1'b0}}, {CW{1'b1}}};

  function automatic logic [W-1:0] mag_sat(input logic signed [PW-1:0] e);
    logic signed [PW-1:0] a;
    a = (e < 0) ? -e : e;
    return (a > MAXM) ? {W{1'b1}} : a[W-1:0];
  endfunction

  function automatic logic [PW-1:0] zx(input logic [W-1:0] x);
    return {{(PW-W){1'b0}}, x};
  endfunction

  logic [W-1:0]  m_i;
  logic [W-1:0]  m_c [NCAP];
  logic [PW-1:0] t_c [NCAP];
  logic [PW-1:0] t_i, vsum, total;

  for (genvar g = 0; g < NCAP; g++) begin : g_term
    assign m_c[g] = mag_sat(PW'(c_ref[g]) - c_nx[g]);
    assign t_c[g] = (zx(m_c[g]) * zx(n_cap[g])) >> FRAC;
  end

  always_comb begin
    m_i  = mag_sat(PW'(i_ref) - i_nx);
    t_i  = (zx(m_i) * zx(n_i)) >> FRAC;
    vsum = '0;
    for (int g = 0; g < NCAP; g++) vsum = vsum + t_c[g];
    total = ((vsum * zx(lam_v)) >> FRAC) + ((t_i * zx(lam_i)) >> FRAC);
    cost  = (total > CMAX) ? CMAX[CW-1:0] : total[CW-1:0];
  end

  // R5: a candidate whose predictions all hit their references scores zero
  always_comb begin
    if (m_i == '0 && m_c[0] == '0 && m_c[1] == '0 && m_c[2] == '0)
      zero_err_zero_cost_chk: assert (cost == '0);
  end
endmodule

// File: rtl/mpc_state_picker.sv
module mpc_state_picker
  import mpc_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int CW   = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid_i,
  output logic                smp_ready_o,
  input  logic signed [W-1:0] v_src_i,
  input  logic signed [W-1:0] v_c2_i,
  input  logic signed [W-1:0] v_c3_i,
  input  logic signed [W-1:0] v_c4_i,
  input  logic signed [W-1:0] i_load_i,
  input  logic signed [W-1:0] v_grid_i,
  input  logic signed [W-1:0] i_ref_i,
  input  logic signed [W-1:0] c2_ref_i,
  input  logic signed [W-1:0] c3_ref_i,
  input  logic signed [W-1:0] c4_ref_i,
  input  logic signed [W-1:0] k_il_i,
  input  logic signed [W-1:0] k_c2_i,
  input  logic signed [W-1:0] k_c3_i,
  input  logic signed [W-1:0] k_c4_i,
  input  logic [W-1:0]        n_i_i,
  input  logic [W-1:0]        n_c2_i,
  input  logic [W-1:0]        n_c3_i,
  input  logic [W-1:0]        n_c4_i,
  input  logic [W-1:0]        lam_v_i,
  input  logic [W-1:0]        lam_i_i,
  output logic                done_o,
  output logic [NSW-1:0]      gate_up_o,
  output logic [NSW-1:0]      gate_dn_o
);
  localparam int PW   = 2*W+8;
  localparam int NST  = 1 << NSW;
  localparam sw_state_t LAST = sw_state_t'(NST-1);

  // latched sample set
  logic signed [W-1:0] q_src, q_il, q_vg, q_iref, q_kil;
  logic signed [W-1:0] q_vc [NCAP];
  logic signed [W-1:0] q_cref [NCAP];
  logic signed [W-1:0] q_kc [NCAP];
  logic [W-1:0]        q_ni, q_lv, q_li;
  logic [W-1:0]        q_nc [NCAP];

  // sequencer state
  logic          busy;
  sw_state_t     cand;
  sw_state_t     best_idx;
  logic [CW-1:0] best_cost;
  sw_state_t     gate_q;
  logic          done_q;

  logic signed [PW-1:0] p_i;
  logic signed [PW-1:0] p_c [NCAP];
  logic [CW-1:0]        cand_cost;
  logic                 take;

  mpc_predict #(.W(W), .FRAC(FRAC), .PW(PW)) u_pred (
    .sw(cand), .v_src(q_src), .v_cap(q_vc), .i_load(q_il), .v_grid(q_vg),
    .k_il(q_kil), .k_cap(q_kc), .i_nx(p_i), .c_nx(p_c)
  );

  mpc_cost #(.W(W), .FRAC(FRAC), .PW(PW), .CW(CW)) u_cost (
    .i_nx(p_i), .c_nx(p_c), .i_ref(q_iref), .c_ref(q_cref), .n_i(q_ni),
    .n_cap(q_nc), .lam_v(q_lv), .lam_i(q_li), .cost(cand_cost)
  );

  // strict compare keeps the lower-numbered state on a tie
  assign take = (cand == '0) || (cand_cost < best_cost);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cand <= '0; best_idx <= '0; best_cost <= '0;
      gate_q <= '0; done_q <= 1'b0;
      q_src <= '0; q_il <= '0; q_vg <= '0; q_iref <= '0; q_kil <= '0;
      q_ni <= '0; q_lv <= '0; q_li <= '0;
      for (int g = 0; g < NCAP; g++) begin
        q_vc[g] <= '0; q_cref[g] <= '0; q_kc[g] <= '0; q_nc[g] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (smp_valid_i) begin
          busy <= 1'b1; cand <= '0;
          q_src <= v_src_i; q_il <= i_load_i; q_vg <= v_grid_i;
          q_iref <= i_ref_i; q_kil <= k_il_i;
          q_ni <= n_i_i; q_lv <= lam_v_i; q_li <= lam_i_i;
          q_vc[0] <= v_c2_i;    q_vc[1] <= v_c3_i;    q_vc[2] <= v_c4_i;
          q_cref[0] <= c2_ref_i; q_cref[1] <= c3_ref_i; q_cref[2] <= c4_ref_i;
          q_kc[0] <= k_c2_i;    q_kc[1] <= k_c3_i;    q_kc[2] <= k_c4_i;
          q_nc[0] <= n_c2_i;    q_nc[1] <= n_c3_i;    q_nc[2] <= n_c4_i;
        end
      end else begin
        if (take) begin
          best_cost <= cand_cost;
          best_idx  <= cand;
        end
        if (cand == LAST) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
          gate_q <= take ? cand : best_idx;
        end else begin
          cand <= cand + 1'b1;
        end
      end
    end
  end

  assign smp_ready_o = !busy;
  assign done_o      = done_q;
  assign gate_up_o   = gate_q;
  assign gate_dn_o   = ~gate_q;

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i && smp_ready_o |=> !smp_ready_o);
  // R2
  ready_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> smp_ready_o);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_up_o) |-> done_o);
  // R7
  best_below_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cand != '0 |-> best_idx < cand);
endmodule

// File: tb/mpc_state_picker_test.sv
`timescale 1ns/1ps
module mpc_state_picker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic smp_valid_i = 1'b0;
  logic signed [15:0] v_src = 0, v_c2 = 0, v_c3 = 0, v_c4 = 0, i_load = 0, v_grid = 0;
  logic signed [15:0] i_ref = 0, c2_ref = 0, c3_ref = 0, c4_ref = 0;
  logic signed [15:0] k_il = 0, k_c2 = 0, k_c3 = 0, k_c4 = 0;
  logic [15:0] n_i = 0, n_c2 = 0, n_c3 = 0, n_c4 = 0, lam_v = 0, lam_i = 0;
  logic smp_ready_o, done_o;
  logic [4:0] gate_up_o, gate_dn_o;

  mpc_state_picker uut (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_ready_o(smp_ready_o),
    .v_src_i(v_src), .v_c2_i(v_c2), .v_c3_i(v_c3), .v_c4_i(v_c4),
    .i_load_i(i_load), .v_grid_i(v_grid), .i_ref_i(i_ref),
    .c2_ref_i(c2_ref), .c3_ref_i(c3_ref), .c4_ref_i(c4_ref),
    .k_il_i(k_il), .k_c2_i(k_c2), .k_c3_i(k_c3), .k_c4_i(k_c4),
    .n_i_i(n_i), .n_c2_i(n_c2), .n_c3_i(n_c3), .n_c4_i(n_c4),
    .lam_v_i(lam_v), .lam_i_i(lam_i),
    .done_o(done_o), .gate_up_o(gate_up_o), .gate_dn_o(gate_dn_o)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: the sample set latched at acceptance
  longint m_src, m_il, m_vg, m_iref, m_kil, m_ni, m_lv, m_li;
  longint m_vc[3], m_cref[3], m_kc[3], m_nc[3];
  bit     m_busy = 0, m_done = 0;
  int     m_left = 0, m_gate = 0, m_win = 0;

  function automatic longint dsw(int s, int a, int b);
    return longint'((s >> a) & 1) - longint'((s >> b) & 1);
  endfunction

  function automatic longint magc(longint e);
    longint a = (e < 0) ? -e : e;
    return (a > 65535) ? 65535 : a;
  endfunction

  function automatic longint score(int s);
    longint vs, ip, cp, tv, ti, tot;
    vs = dsw(s,0,1)*m_src + dsw(s,1,2)*m_vc[0] + dsw(s,2,3)*m_vc[1]
       + dsw(s,3,4)*m_vc[2] - m_vg;
    ip = m_il + ((m_kil * vs) >>> 14);                    // R3
    ti = (magc(m_iref - ip) * m_ni) >> 14;
    tv = 0;
    for (int j = 0; j < 3; j++) begin
      cp = m_vc[j] + ((m_kc[j] * (dsw(s, j+2, j+1) * m_il)) >>> 14);   // R4
      tv = tv + ((magc(m_cref[j] - cp) * m_nc[j]) >> 14);
    end
    tot = ((tv * m_lv) >> 14) + ((ti * m_li) >> 14);     // R5
    return (tot > 1048575) ? 1048575 : tot;               // R6
  endfunction

  function automatic int pick();
    int w = 0; longint c, best = 0;
    for (int s = 0; s < 32; s++) begin
      c = score(s);
      if (s == 0 || c < best) begin best = c; w = s; end  // R7
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_gate = 0; m_left = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; m_gate = m_win; end
      end else if (smp_valid_i) begin
        m_src = v_src; m_il = i_load; m_vg = v_grid; m_iref = i_ref; m_kil = k_il;
        m_ni = n_i; m_lv = lam_v; m_li = lam_i;
        m_vc[0] = v_c2; m_vc[1] = v_c3; m_vc[2] = v_c4;
        m_cref[0] = c2_ref; m_cref[1] = c3_ref; m_cref[2] = c4_ref;
        m_kc[0] = k_c2; m_kc[1] = k_c3; m_kc[2] = k_c4;
        m_nc[0] = n_c2; m_nc[1] = n_c3; m_nc[2] = n_c4;
        m_win = pick(); m_busy = 1; m_left = 32;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 ready", smp_ready_o, !m_busy);
      chk("R8 done", done_o, m_done);
      chk("R1 gate_up", gate_up_o, m_gate);
      chk("R1 gate_dn", gate_dn_o, (~m_gate) & 31);
    end
  end

  task automatic run_one(input string tag);
    @(negedge clk); smp_valid_i = 1'b1;
    @(negedge clk); smp_valid_i = 1'b0;
    repeat (36) @(negedge clk);
    chk(tag, gate_up_o, m_win);
  endtask

  initial begin
    #(4*200000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset gate_up", gate_up_o, 0);
    chk("R1 reset gate_dn", gate_dn_o, 31);
    chk("R8 reset done", done_o, 0);

    // current-led selection
    v_src = 4000; v_c2 = 1867; v_c3 = 800; v_c4 = 267; i_load = 100; v_grid = 1500;
    i_ref = 300; c2_ref = 1867; c3_ref = 800; c4_ref = 267;
    k_il = 2048; k_c2 = 1000; k_c3 = 1000; k_c4 = 1000;
    n_i = 16384; n_c2 = 0; n_c3 = 0; n_c4 = 0; lam_v = 16384; lam_i = 16384;
    run_one("R3 current prediction winner");
    v_grid = -2500; i_ref = -900; i_load = -200;
    run_one("R3 negative drive winner");

    // capacitor-led selection
    lam_i = 0; n_c2 = 16384; n_c3 = 16384; n_c4 = 16384;
    c2_ref = 1900; c3_ref = 780; c4_ref = 270; i_load = -500;
    k_c2 = 3000; k_c3 = 6000; k_c4 = 12000;
    run_one("R4 capacitor prediction winner");

    // combined cost
    lam_i = 8192; lam_v = 20000; n_i = 12000; n_c2 = 9000; n_c3 = 15000; n_c4 = 30000;
    i_load = 750; i_ref = 900; v_grid = 1200; k_il = 3000;
    run_one("R5 combined cost winner");

    // clamped cost
    v_c2 = -30000; v_c3 = -30000; v_c4 = -30000;
    c2_ref = 30000; c3_ref = 30000; c4_ref = 30000;
    n_c2 = 40000; n_c3 = 40000; n_c4 = 40000; lam_v = 65535;
    i_load = 20000; k_c2 = 16000; k_c3 = 16000; k_c4 = 16000; lam_i = 0;
    run_one("R6 saturating cost winner");

    // ties: only capacitor 4 term counts, best set is states 16..23
    v_src = 0; v_c2 = 0; v_c3 = 0; v_c4 = 0; v_grid = 0; i_load = 1000;
    c4_ref = 500; k_c4 = 8192; n_c2 = 0; n_c3 = 0; n_c4 = 16384;
    lam_v = 16384; lam_i = 0;
    run_one("R7 tie goes to lowest state");
    n_c4 = 0;
    run_one("R7 all-equal tie picks state 0");

    // inputs move during evaluation, valid held high
    n_c4 = 16384; c4_ref = -500; n_i = 16384; lam_i = 16384; k_il = 4000;
    v_src = 3000; v_grid = 700; i_ref = 400;
    @(negedge clk); smp_valid_i = 1'b1;
    repeat (5) @(negedge clk);
    c4_ref = 500; v_grid = -3000; i_ref = -5000; k_c4 = -8000;
    repeat (30) @(negedge clk);
    chk("R9 winner from latched set", gate_up_o, m_win);
    repeat (40) @(negedge clk);
    smp_valid_i = 1'b0;
    repeat (36) @(negedge clk);
    chk("R2 back-to-back result", gate_up_o, m_win);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule